// File: doc/BRIEF.md
# Calibration Register Bank with Auto-Advancing Pointer

This block holds ten 14-bit calibration words: one gain word, one offset word and eight DAC trim words. A host reaches them through a parallel port that moves either a full 16-bit word or one byte at a time. The host never sends an address. A control write loads a two-bit window code, which chooses the subset of registers that later accesses cover. An internal pointer then moves through that subset by itself, one step for each completed register access.

The control write also loads a two-bit read-select field. Reads return register data only while that field holds the calibration read code. In byte mode the host transfers the low byte first and the high byte second. The pointer moves only when the high byte completes. A sequence can stop at any point. The next control write moves the pointer back to the start of the selected window.

All port signals are plain single-cycle strobes sampled on the rising clock edge. The port has no valid/ready flow. The host issues at most one access per cycle, and the block never applies back-pressure. Read data is combinational: it reflects the current pointer and the byte-lane inputs, and the host samples it in the same cycle in which it raises the read strobe.

Top module: `calreg_bank`

## Requirements
- R1: After reset the offset register holds 0x2000 and every other register holds 0. The window code is 00, the pointer is on the gain register and the read-select field is 00, so reads return 0.
- R2: Window code 00 covers all ten registers in this fixed order: gain, offset, then DAC trim words 1 to 8.
- R3: Window code 01 covers gain followed by offset. Code 10 covers the offset register alone. Code 11 covers the gain register alone.
- R4: Every control write (ctl_wr high) places the pointer on the first register of the newly loaded window. That is the offset register for code 10 and the gain register for every other code. This also holds after a sequence has been abandoned partway.
- R5: The pointer advances by one register after each completed access. When the access to the last register of the window completes, the pointer returns to the first register of that window.
- R6: In byte mode (byte_mode=1), an access with hi_en=0 moves data bits 7:0 and leaves the pointer in place. An access with hi_en=1 moves data bits 13:8 (carried on port bits 5:0) and then advances the pointer. A byte read places its byte in rd_data[7:0], and rd_data[15:8] is zero.
- R7: A word write stores wr_data[13:0] and ignores wr_data[15:14]. Every read returns zero in rd_data[15:14].
- R8: Reads are enabled only while the read-select field equals 10. Otherwise rd_data is zero, and a read strobe neither moves the pointer nor changes any register.
- R9: If wr_stb and rd_stb are high in the same cycle, no register changes and the pointer stays where it is.
- R10: An access strobe in the same cycle as ctl_wr is ignored. The control write alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ctl_wr | input | 1 | Control write strobe; loads ctl_sel and ctl_rdsel |
| ctl_sel | input | 2 | Window code loaded by a control write |
| ctl_rdsel | input | 2 | Read-select field; 10 enables calibration reads |
| wr_stb | input | 1 | Data write strobe |
| rd_stb | input | 1 | Data read strobe (completes a read access) |
| byte_mode | input | 1 | 1 selects byte transfers, 0 selects word transfers |
| hi_en | input | 1 | In byte mode, 1 selects the high byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the register under the pointer |

## Verification
The embedded assertions check the following on every cycle:
- the pointer stays inside the selected window;
- a control write lands the pointer on the window's first register;
- each completed access steps or wraps the pointer correctly;
- nothing moves the pointer when no access completes;
- the top two read bits are zero;
- a low-byte write leaves the high field alone.

Other behaviours are visible only through the bench's scenarios, which compare read-back values against a bench-side model:
- the physical order of the ten registers;
- the power-up contents;
- masking of the upper write bits;
- the effect of an abandoned sequence;
- the ignoring of colliding strobes.

// File: rtl/calreg_pkg.sv
package calreg_pkg;

  typedef enum logic [1:0] {
    SEL_ALL  = 2'b00,
    SEL_PAIR = 2'b01,
    SEL_OFS  = 2'b10,
    SEL_GAIN = 2'b11
  } cal_sel_e;

  localparam logic [1:0] RDSEL_CAL = 2'b10;
  localparam int unsigned POS_GAIN = 0;
  localparam int unsigned POS_OFS  = 1;

  // first physical position of a window
  function automatic int unsigned win_first(cal_sel_e s);
    return (s == SEL_OFS) ? POS_OFS : POS_GAIN;
  endfunction

  // last physical position of a window
  function automatic int unsigned win_last(cal_sel_e s, int unsigned nreg);
    case (s)
      SEL_ALL:  return nreg - 1;
      SEL_PAIR: return POS_OFS;
      SEL_OFS:  return POS_OFS;
      default:  return POS_GAIN;
    endcase
  endfunction

endpackage

// File: rtl/calreg_ptr.sv
module calreg_ptr
  import calreg_pkg::*;
#(
  parameter int NREG = 10,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  cal_sel_e         sel_in,
  input  logic             step,
  output logic [IDX_W-1:0] ptr,
  output cal_sel_e         sel
);

  logic [IDX_W-1:0] first_q, last_q, first_n;

  assign first_q = IDX_W'(win_first(sel));
  assign last_q  = IDX_W'(win_last(sel, NREG));
  assign first_n = IDX_W'(win_first(sel_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= SEL_ALL;
      ptr <= IDX_W'(POS_GAIN);
    end else if (load) begin
      sel <= sel_in;
      ptr <= first_n;
    end else if (step) begin
      ptr <= (ptr == last_q) ? first_q : ptr + 1'b1;
    end
  end

  // R4
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == IDX_W'(win_first(sel))));

  // R3
  ptr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= first_q) && (ptr <= last_q));

  // R5
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr != last_q) |=> (ptr == $past(ptr) + 1'b1));

  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == last_q) |=> (ptr == first_q));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr));

endmodule

// File: rtl/calreg_store.sv
module calreg_store
  import calreg_pkg::*;
#(
  parameter int NREG = 10,
  parameter int DATA_W = 14,
  parameter int PORT_W = 16,
  parameter logic [DATA_W-1:0] OFS_RST = 14'h2000,
  localparam int IDX_W = $clog2(NREG),
  localparam int LO_W = 8,
  localparam int HI_W = DATA_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              byte_mode,
  input  logic              hi_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [DATA_W-1:0] rdat
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = (g == POS_OFS) ? OFS_RST : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= RST_V;
      end else if (we && idx == IDX_W'(g)) begin
        if (!byte_mode)  regs[g] <= wdata[DATA_W-1:0];
        else if (hi_en)  regs[g][DATA_W-1:LO_W] <= wdata[HI_W-1:0];
        else             regs[g][LO_W-1:0] <= wdata[LO_W-1:0];
      end
    end
  end

  assign rdat = ({1'b0, idx} < (IDX_W+1)'(NREG)) ? regs[idx] : '0;

  // R6
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && byte_mode && !hi_en) |=> (rdat[DATA_W-1:LO_W] == $past(rdat[DATA_W-1:LO_W])));

endmodule

// File: rtl/calreg_bank.sv
module calreg_bank
  import calreg_pkg::*;
#(
  parameter int NUM_DAC = 8,
  parameter int DATA_W = 14,
  parameter int PORT_W = 16,
  parameter logic [DATA_W-1:0] OFS_RST = 14'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_sel,
  input  logic [1:0]        ctl_rdsel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              byte_mode,
  input  logic              hi_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data
);

  localparam int NREG  = NUM_DAC + 2;
  localparam int IDX_W = $clog2(NREG);
  localparam int LO_W  = 8;
  localparam int HI_W  = DATA_W - LO_W;

  logic [1:0]        rdsel_q;
  logic              rd_en, acc_ok, we, step;
  logic [IDX_W-1:0]  ptr;
  cal_sel_e          sel;
  logic [DATA_W-1:0] rdat;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdsel_q <= 2'b00;
    else if (ctl_wr) rdsel_q <= ctl_rdsel;
  end

  assign rd_en  = (rdsel_q == RDSEL_CAL);
  assign acc_ok = !ctl_wr && (wr_stb ^ rd_stb) && (wr_stb || rd_en);
  assign we     = acc_ok && wr_stb;
  assign step   = acc_ok && (!byte_mode || hi_en);

  calreg_ptr #(.NREG(NREG)) ptr_i (
    .clk(clk), .rst_n(rst_n), .load(ctl_wr), .sel_in(cal_sel_e'(ctl_sel)),
    .step(step), .ptr(ptr), .sel(sel)
  );

  calreg_store #(.NREG(NREG), .DATA_W(DATA_W), .PORT_W(PORT_W), .OFS_RST(OFS_RST)) store_i (
    .clk(clk), .rst_n(rst_n), .we(we), .idx(ptr), .byte_mode(byte_mode),
    .hi_en(hi_en), .wdata(wr_data), .rdat(rdat)
  );

  always_comb begin
    if (!rd_en)         rd_data = '0;
    else if (!byte_mode) rd_data = PORT_W'(rdat);
    else if (hi_en)     rd_data = PORT_W'(rdat[DATA_W-1:LO_W]);
    else                rd_data = PORT_W'(rdat[LO_W-1:0]);
  end

  // R7
  rd_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PORT_W-1:DATA_W] == '0);

  // R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdsel_q != RDSEL_CAL) |-> (rd_data == '0));

  // R6
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (rd_data[PORT_W-1:LO_W] == '0));

endmodule

// File: tb/calreg_bank_tb.sv
`timescale 1ns/1ps
module calreg_bank_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, byte_mode = 1'b0, hi_en = 1'b0;
  logic [1:0] ctl_sel = 2'b00, ctl_rdsel = 2'b00;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;

  logic [13:0] m_reg [10];
  int m_ptr;
  logic [1:0] m_sel;
  logic [1:0] m_rd;

  always #10 clk = ~clk;

  calreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_rdsel(ctl_rdsel),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .byte_mode(byte_mode), .hi_en(hi_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int f_first(logic [1:0] s);
    return (s == 2'b10) ? 1 : 0;
  endfunction

  function automatic int f_last(logic [1:0] s);
    case (s)
      2'b00: return 9;
      2'b01: return 1;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] f_rexp(logic bm, logic he);
    logic [13:0] v;
    v = m_reg[m_ptr];
    if (m_rd != 2'b10) return 16'h0;
    if (!bm) return {2'b00, v};
    if (he)  return {10'h0, v[13:8]};
    return {8'h0, v[7:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [1:0] s, input logic [1:0] rs,
                     input logic w = 1'b0, input logic [15:0] d = '0);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_sel = s; ctl_rdsel = rs; wr_stb = w; wr_data = d;
    @(posedge clk); #1;
    ctl_wr = 1'b0; wr_stb = 1'b0;
    m_sel = s; m_rd = rs; m_ptr = f_first(s);
  endtask

  // one access cycle; checks read data when rd_stb is high
  task automatic op(input string tag, input logic w, input logic r,
                    input logic bm, input logic he, input logic [15:0] d);
    logic en;
    @(negedge clk);
    wr_stb = w; rd_stb = r; byte_mode = bm; hi_en = he; wr_data = d;
    #2;
    if (r) check(tag, rd_data, f_rexp(bm, he));
    @(posedge clk); #1;
    wr_stb = 1'b0; rd_stb = 1'b0;
    en = (w ^ r) && (w || m_rd == 2'b10);
    if (en && w) begin
      if (!bm)     m_reg[m_ptr] = d[13:0];
      else if (he) m_reg[m_ptr][13:8] = d[5:0];
      else         m_reg[m_ptr][7:0] = d[7:0];
    end
    if (en && (!bm || he))
      m_ptr = (m_ptr == f_last(m_sel)) ? f_first(m_sel) : m_ptr + 1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 10; i++) m_reg[i] = (i == 1) ? 14'h2000 : 14'h0;
    m_ptr = 0; m_sel = 2'b00; m_rd = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset: reads disabled, return zero
    op("R1 reset read gated", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R1 default window 00 from gain: read back defaults first
    ctl(2'b00, 2'b10);
    for (int i = 0; i < 10; i++) op("R1 reset contents", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R2 order, R7 upper write bits dropped
    ctl(2'b00, 2'b00);
    for (int i = 0; i < 10; i++) op("R7 word write", 1'b1, 1'b0, 1'b0, 1'b0, 16'hC000 | 16'(i * 16'h0111 + 1));
    ctl(2'b00, 2'b10);
    for (int i = 0; i < 11; i++) op("R2 order and R5 wrap", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R3 windows
    ctl(2'b01, 2'b10);
    for (int i = 0; i < 3; i++) op("R3 pair window", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    ctl(2'b10, 2'b10);
    op("R4 offset start", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    op("R3 offset only", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    ctl(2'b11, 2'b10);
    op("R3 gain only", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    op("R3 gain only repeat", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R4 abandon partway then restart
    ctl(2'b00, 2'b10);
    for (int i = 0; i < 4; i++) op("R5 step", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    ctl(2'b00, 2'b10);
    op("R4 abandon resets to gain", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R6 byte mode
    ctl(2'b01, 2'b00);
    op("R6 lo write", 1'b1, 1'b0, 1'b1, 1'b0, 16'h00A5);
    op("R6 hi write", 1'b1, 1'b0, 1'b1, 1'b1, 16'h00FF);
    ctl(2'b01, 2'b10);
    op("R6 lo read", 1'b0, 1'b1, 1'b1, 1'b0, '0);
    op("R6 lo read no advance", 1'b0, 1'b1, 1'b1, 1'b0, '0);
    op("R6 hi read", 1'b0, 1'b1, 1'b1, 1'b1, '0);
    op("R6 advanced to offset", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R8 disabled reads do not move pointer
    ctl(2'b00, 2'b01);
    op("R8 gated read", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    op("R8 gated read", 1'b0, 1'b1, 1'b0, 1'b0, '0);
    op("R8 write after gated", 1'b1, 1'b0, 1'b0, 1'b0, 16'h1357);
    // R9 collision
    op("R9 collide", 1'b1, 1'b1, 1'b0, 1'b0, 16'h3FFF);
    // R10 access with control write
    ctl(2'b00, 2'b00, 1'b1, 16'h2AAA);
    ctl(2'b00, 2'b10);
    for (int i = 0; i < 3; i++) op("R8 R9 R10 readback", 1'b0, 1'b1, 1'b0, 1'b0, '0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 16);
      if (k == 0) ctl(2'($urandom), ($urandom % 4 == 0) ? 2'b00 : 2'b10);
      else if (k < 7) op("R5 R6 random write", 1'b1, 1'b0, 1'($urandom), 1'($urandom), 16'($urandom));
      else if (k < 15) op("R5 R6 random read", 1'b0, 1'b1, 1'($urandom), 1'($urandom), '0);
      else op("R9 random collide", 1'b1, 1'b1, 1'($urandom), 1'($urandom), 16'($urandom));
    end
    // final sweep of all contents
    ctl(2'b00, 2'b10);
    for (int i = 0; i < 10; i++) op("R2 R7 final sweep", 1'b0, 1'b1, 1'b0, 1'b0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule